// File: doc/BRIEF.md
# I2C Register Target with Alert Response

This block is the serial-bus face of a multi-port power controller. It answers a 7-bit I2C address made of the fixed bits 010 and four strap inputs. A host uses it to write a small register file, read any register back, and service an interrupt.

Event pulses from the port logic latch into a sticky event register. A mask register gates which latched events may pull the open-drain interrupt output low. A write-only command register releases that output or clears the events. The interrupt output only moves while the bus is idle, so a host never sees it change in the middle of a transfer.

The host has three ways to read. A normal read sends a register address and then a repeated start. A short-form read skips the register address and returns the event register. An alert-response query returns the device's own address byte. Data in and data out are separate pins, so the bus can be isolated; the output only ever pulls low.

Top module: `alert_i2c_target`

## Requirements
- R1: After reset the SDA and interrupt pull outputs are inactive (0), and both the mask register (address 01h) and the event register (address 00h) read 00h.
- R2: The target acknowledges an address byte whose upper seven bits are {010, strap_i[3:0]}. It does not acknowledge any other address, and leaves SDA released.
- R3: A write is: address byte with R/W=0, then a register address byte, then a data byte. The target acknowledges all three bytes and stores the data at that register address.
- R4: After a register address is sent, a repeated start with R/W=1 returns the register at that address (00h event, 01h mask, any other address 00h).
- R5: A read with R/W=1 right after a start, with no register address earlier in the same transaction, returns the event register. A pointer set in an earlier transaction is not used.
- R6: The address byte 0001100 with R/W=1 is acknowledged and answered with {010, strap_i, 1}. The same address with R/W=0 is not acknowledged.
- R7: A one-cycle pulse on bit n of evt_i sets bit n of the event register. The bit stays set until it is cleared by command.
- R8: int_pull_o goes to 1 when a latched event bit has its mask bit set and the bus is idle. Latched events whose mask bit is 0 leave it at 0.
- R9: int_pull_o keeps its value from a start condition until the matching stop. An event that arrives during a transaction asserts the output only after the stop.
- R10: Writing data with bit 7 set to register 1Ah clears the event register and releases int_pull_o once the transaction ends.
- R11: Writing data with bit 6 set to register 1Ah releases int_pull_o but keeps the event bits. A new masked event afterwards asserts the output again.
- R12: During a read, if the master acknowledges a data byte, the same byte is sent again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls the bus data line low |
| strap_i | input | 4 | Low four bits of the device address |
| evt_i | input | 8 | Event pulses from the port logic, one per bit |
| int_pull_o | output | 1 | 1 pulls the interrupt line low |

## Verification
The hardest case to reach is an event arriving while a transaction is open. The stimulus starts a transfer and stops after the address acknowledge. It pulses a masked event while SCL is low, samples the interrupt output before the stop and again after it. A second hard case is a pointer that must not outlive its transaction. A full register read is followed by a short-form read, which has to return the event register and not the register pointed to earlier. Release-only and clear-all commands are told apart by reading the event register after each one. An acknowledged data byte is used to check that the same byte is sent again.

// File: rtl/ait_pkg.sv
package ait_pkg;
    localparam logic [6:0] DEV_BASE = 7'b0100000;
    localparam logic [6:0] ARA_ADDR = 7'b0001100;
    localparam logic [7:0] REG_EVT  = 8'h00;
    localparam logic [7:0] REG_MASK = 8'h01;
    localparam logic [7:0] REG_CMD  = 8'h1A;
    localparam int CMD_CLR_ALL = 7;
    localparam int CMD_RELEASE = 6;

    typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK, ST_WAIT} link_st_e;
    typedef enum logic [1:0] {K_DEV, K_REG, K_DATA} rx_kind_e;
    typedef enum logic [1:0] {N_REG, N_DATA, N_TX, N_WAIT} after_ack_e;
endpackage

// File: rtl/ait_sync.sv
module ait_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ait_cond.sv
module ait_cond (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o,
    output logic busy_o
);
    typedef struct packed {
        logic scl;
        logic sda;
        logic busy;
    } cond_t;

    cond_t q, d;

    always_comb begin
        d       = q;
        d.scl   = scl_s_i;
        d.sda   = sda_s_i;
        rise_o  = ~q.scl & scl_s_i;
        fall_o  = q.scl & ~scl_s_i;
        start_o = q.scl & scl_s_i & q.sda & ~sda_s_i;
        stop_o  = q.scl & scl_s_i & ~q.sda & sda_s_i;
        if (start_o)     d.busy = 1'b1;
        else if (stop_o) d.busy = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{scl: 1'b1, sda: 1'b1, busy: 1'b0};
        else         q <= d;
    end

    assign busy_o = q.busy;
endmodule

// File: rtl/ait_link.sv
module ait_link
    import ait_pkg::*;
#(
    parameter int STRAP_W = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               rise_i,
    input  logic               fall_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               sda_s_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [7:0]         rd_data_i,
    output logic [7:0]         rd_addr_o,
    output logic               wr_en_o,
    output logic [7:0]         wr_addr_o,
    output logic [7:0]         wr_data_o,
    output logic               sda_pull_o
);
    typedef struct packed {
        link_st_e   st;
        rx_kind_e   kind;
        after_ack_e nxt;
        logic [2:0] cnt;
        logic [7:0] sh;
        logic       pull;
        logic [7:0] ptr;
        logic       ptr_ok;
        logic       ack_ph;
        logic       mack;
        logic       ara;
    } link_t;

    link_t q, d;
    logic [7:0] rx_byte;
    logic [7:0] tx_byte;
    logic [6:0] dev_id;

    always_comb begin
        d         = q;
        dev_id    = {DEV_BASE[6:STRAP_W], strap_i};
        rx_byte   = {q.sh[6:0], sda_s_i};
        rd_addr_o = q.ptr_ok ? q.ptr : REG_EVT;
        tx_byte   = q.ara ? {dev_id, 1'b1} : rd_data_i;
        wr_en_o   = 1'b0;
        wr_addr_o = q.ptr;
        wr_data_o = rx_byte;
        if (stop_i) begin
            d.st     = ST_IDLE;
            d.pull   = 1'b0;
            d.ptr_ok = 1'b0;
        end else if (start_i) begin
            d.st   = ST_RX;
            d.kind = K_DEV;
            d.cnt  = 3'd0;
            d.pull = 1'b0;
            d.ara  = 1'b0;
        end else begin
            case (q.st)
                ST_RX: if (rise_i) begin
                    d.sh  = rx_byte;
                    d.cnt = q.cnt + 3'd1;
                    if (q.cnt == 3'd7) begin
                        d.st     = ST_WAIT;
                        d.ack_ph = 1'b0;
                        case (q.kind)
                            K_DEV: begin
                                if (rx_byte[7:1] == dev_id) begin
                                    d.st  = ST_ACK;
                                    d.nxt = rx_byte[0] ? N_TX : N_REG;
                                end else if (rx_byte[7:1] == ARA_ADDR && rx_byte[0]) begin
                                    d.st  = ST_ACK;
                                    d.nxt = N_TX;
                                    d.ara = 1'b1;
                                end
                            end
                            K_REG: begin
                                d.ptr    = rx_byte;
                                d.ptr_ok = 1'b1;
                                d.st     = ST_ACK;
                                d.nxt    = N_DATA;
                            end
                            default: begin
                                wr_en_o = 1'b1;
                                d.st    = ST_ACK;
                                d.nxt   = N_WAIT;
                            end
                        endcase
                    end
                end
                ST_ACK: if (fall_i) begin
                    if (!q.ack_ph) begin
                        d.pull   = 1'b1;
                        d.ack_ph = 1'b1;
                    end else begin
                        d.pull = 1'b0;
                        d.cnt  = 3'd0;
                        case (q.nxt)
                            N_REG:  begin d.st = ST_RX; d.kind = K_REG;  end
                            N_DATA: begin d.st = ST_RX; d.kind = K_DATA; end
                            N_TX: begin
                                d.st   = ST_TX;
                                d.sh   = tx_byte;
                                d.pull = ~tx_byte[7];
                            end
                            default: d.st = ST_WAIT;
                        endcase
                    end
                end
                ST_TX: if (fall_i) begin
                    if (q.cnt == 3'd7) begin
                        d.pull = 1'b0;
                        d.st   = ST_RACK;
                    end else begin
                        d.sh   = {q.sh[6:0], 1'b0};
                        d.pull = ~q.sh[6];
                        d.cnt  = q.cnt + 3'd1;
                    end
                end
                ST_RACK: begin
                    if (rise_i) d.mack = ~sda_s_i;
                    if (fall_i) begin
                        if (q.mack) begin
                            d.st   = ST_TX;
                            d.sh   = tx_byte;
                            d.pull = ~tx_byte[7];
                            d.cnt  = 3'd0;
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{st: ST_IDLE, kind: K_DEV, nxt: N_WAIT, default: '0};
        else         q <= d;
    end

    assign sda_pull_o = q.pull;
endmodule

// File: rtl/ait_regs.sv
module ait_regs
    import ait_pkg::*;
#(
    parameter int               EVT_W    = 8,
    parameter logic [EVT_W-1:0] MASK_RST = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             busy_i,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             wr_en_i,
    input  logic [7:0]       wr_addr_i,
    input  logic [7:0]       wr_data_i,
    input  logic [7:0]       rd_addr_i,
    output logic [7:0]       rd_data_o,
    output logic [EVT_W-1:0] evt_o,
    output logic [EVT_W-1:0] mask_o,
    output logic             int_pull_o
);
    typedef struct packed {
        logic [EVT_W-1:0] evt;
        logic [EVT_W-1:0] mask;
        logic             silent;
        logic             irq;
    } regs_t;

    regs_t q, d;
    logic cmd_wr;
    logic fresh;

    always_comb begin
        d      = q;
        cmd_wr = wr_en_i && (wr_addr_i == REG_CMD);
        fresh  = |(evt_i & ~q.evt & q.mask);
        d.evt  = ((cmd_wr && wr_data_i[CMD_CLR_ALL]) ? '0 : q.evt) | evt_i;
        if (wr_en_i && wr_addr_i == REG_MASK) d.mask = wr_data_i[EVT_W-1:0];
        if (cmd_wr && (wr_data_i[CMD_CLR_ALL] || wr_data_i[CMD_RELEASE])) d.silent = 1'b1;
        else if (fresh)                                                   d.silent = 1'b0;
        if (!busy_i) d.irq = (|(q.evt & q.mask)) & ~q.silent;
        rd_data_o = '0;
        case (rd_addr_i)
            REG_EVT:  rd_data_o[EVT_W-1:0] = q.evt;
            REG_MASK: rd_data_o[EVT_W-1:0] = q.mask;
            default:  ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{evt: '0, mask: MASK_RST, silent: 1'b0, irq: 1'b0};
        else         q <= d;
    end

    assign evt_o      = q.evt;
    assign mask_o     = q.mask;
    assign int_pull_o = q.irq;
endmodule

// File: rtl/alert_i2c_target.sv
module alert_i2c_target #(
    parameter int SYNC_STAGES = 2,
    parameter int STRAP_W     = 4,
    parameter int EVT_W       = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [EVT_W-1:0]   evt_i,
    output logic               int_pull_o
);
    logic scl_s, sda_s;
    logic rise, fall, start, stop, bus_busy;
    logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
    logic wr_en;
    logic [EVT_W-1:0] evt_w, mask_w;

    ait_sync #(.STAGES(SYNC_STAGES), .W(2)) sync_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
    );

    ait_cond cond_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
        .rise_o(rise), .fall_o(fall), .start_o(start), .stop_o(stop), .busy_o(bus_busy)
    );

    ait_link #(.STRAP_W(STRAP_W)) link_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .fall_i(fall),
        .start_i(start), .stop_i(stop), .sda_s_i(sda_s), .strap_i(strap_i),
        .rd_data_i(rd_data), .rd_addr_o(rd_addr), .wr_en_o(wr_en),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data), .sda_pull_o(sda_pull_o)
    );

    ait_regs #(.EVT_W(EVT_W)) regs_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(bus_busy), .evt_i(evt_i),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .evt_o(evt_w),
        .mask_o(mask_w), .int_pull_o(int_pull_o)
    );
endmodule

// File: rtl/ait_chk.sv
module ait_chk #(
    parameter int EVT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             busy_i,
    input logic             scl_s_i,
    input logic             sda_pull_i,
    input logic             int_pull_i,
    input logic [EVT_W-1:0] evt_i,
    input logic [EVT_W-1:0] mask_i
);
    // R9: interrupt output frozen while a transaction is open
    p_int_hold_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(busy_i) |-> $stable(int_pull_i));

    // R2: data line pulled only while the clock is low
    p_pull_scl_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sda_pull_i) |-> !$past(scl_s_i));

    // R1: no data-line drive outside a transaction
    p_quiet_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_i |-> !sda_pull_i);

    // R8: interrupt only rises on a masked latched event
    p_int_needs_event_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(int_pull_i) |-> $past(|(evt_i & mask_i)));
endmodule

bind alert_i2c_target ait_chk #(.EVT_W(EVT_W)) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(bus_busy), .scl_s_i(scl_s),
    .sda_pull_i(sda_pull_o), .int_pull_i(int_pull_o), .evt_i(evt_w), .mask_i(mask_w)
);

// File: tb/alert_i2c_target_tb_top.sv
module alert_i2c_target_tb_top;
    localparam int Q = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [3:0] strap = 4'b0101;
    logic [7:0] evt = 8'h00;
    logic sda_pull, int_pull;
    logic sda_line;

    always #4 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    alert_i2c_target dut_i (
        .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .strap_i(strap), .evt_i(evt), .int_pull_o(int_pull)
    );

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];
    logic [7:0] got_b;
    event got_ev;
    logic [7:0] dev_w, dev_r;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    initial forever begin
        @(got_ev);
        if (exp_q.size() == 0) begin
            check(1'b0, "R4", "unexpected read byte", got_b, 8'h00);
        end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(got_b == e, t, "read byte", got_b, e);
        end
    end

    task automatic bit_out(input logic b);
        sda_m = b; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; b = sda_line; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #(4*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(nack);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) bit_in(b[i]);
        bit_out(mack ? 1'b0 : 1'b1);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, input string tag);
        logic n;
        bus_start();
        send_byte(dev_w, n); check(n == 1'b0, "R2", {tag, " address ack"}, {7'd0, n}, 8'h00);
        send_byte(a, n);     check(n == 1'b0, "R3", {tag, " register ack"}, {7'd0, n}, 8'h00);
        send_byte(d, n);     check(n == 1'b0, "R3", {tag, " data ack"}, {7'd0, n}, 8'h00);
        bus_stop();
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [7:0] exp, input string tag);
        logic n;
        logic [7:0] b;
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_start();
        send_byte(dev_w, n); check(n == 1'b0, "R2", "read address ack", {7'd0, n}, 8'h00);
        send_byte(a, n);     check(n == 1'b0, "R4", "pointer ack", {7'd0, n}, 8'h00);
        bus_start();
        send_byte(dev_r, n); check(n == 1'b0, "R4", "restart ack", {7'd0, n}, 8'h00);
        recv_byte(1'b0, b);
        got_b = b; ->got_ev;
        bus_stop();
    endtask

    task automatic rd_short(input logic [7:0] exp, input int cnt, input string tag);
        logic n;
        logic [7:0] b;
        for (int k = 0; k < cnt; k++) begin exp_q.push_back(exp); tag_q.push_back(tag); end
        bus_start();
        send_byte(dev_r, n); check(n == 1'b0, "R5", "short read ack", {7'd0, n}, 8'h00);
        for (int k = 0; k < cnt; k++) begin
            recv_byte(k < cnt - 1, b);
            got_b = b; ->got_ev;
        end
        bus_stop();
    endtask

    task automatic pulse(input logic [7:0] v);
        @(negedge clk) evt = v;
        @(negedge clk) evt = 8'h00;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(150000 * 8);
        check(1'b0, "R1", "watchdog expired", 8'h01, 8'h00);
        summary();
        $finish;
    end

    initial begin
        logic n;
        logic [7:0] b;
        dev_w = {3'b010, strap, 1'b0};
        dev_r = {3'b010, strap, 1'b1};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(sda_pull == 1'b0, "R1", "sda pull after reset", {7'd0, sda_pull}, 8'h00);
        check(int_pull == 1'b0, "R1", "int pull after reset", {7'd0, int_pull}, 8'h00);
        rd_reg(8'h01, 8'h00, "R1");
        rd_short(8'h00, 1, "R1");

        // R2: foreign address not acknowledged
        bus_start();
        send_byte(8'h5A, n);
        check(n == 1'b1, "R2", "foreign address nack", {7'd0, n}, 8'h01);
        bus_stop();

        // R3 / R4: mask write and read back through the pointer
        wr_reg(8'h01, 8'h0F, "R3");
        rd_reg(8'h01, 8'h0F, "R4");
        rd_reg(8'h33, 8'h00, "R4");

        // R7 / R8: unmasked events latch without interrupt
        pulse(8'h30);
        #(2*Q);
        check(int_pull == 1'b0, "R8", "unmasked event int", {7'd0, int_pull}, 8'h00);
        rd_short(8'h30, 1, "R5");
        rd_short(8'h30, 1, "R7");

        // R6: alert response query
        exp_q.push_back({3'b010, strap, 1'b1}); tag_q.push_back("R6");
        bus_start();
        send_byte({7'b0001100, 1'b1}, n);
        check(n == 1'b0, "R6", "alert query ack", {7'd0, n}, 8'h00);
        recv_byte(1'b0, b);
        got_b = b; ->got_ev;
        bus_stop();
        bus_start();
        send_byte({7'b0001100, 1'b0}, n);
        check(n == 1'b1, "R6", "alert write nack", {7'd0, n}, 8'h01);
        bus_stop();

        // R9: event inside a transaction
        bus_start();
        send_byte(dev_w, n);
        check(n == 1'b0, "R2", "address ack", {7'd0, n}, 8'h00);
        pulse(8'h01);
        #(4*Q);
        check(int_pull == 1'b0, "R9", "int held during transaction", {7'd0, int_pull}, 8'h00);
        bus_stop();
        check(int_pull == 1'b1, "R9", "int after stop", {7'd0, int_pull}, 8'h01);

        // R11: release only
        wr_reg(8'h1A, 8'h40, "R11");
        check(int_pull == 1'b0, "R11", "int released", {7'd0, int_pull}, 8'h00);
        rd_short(8'h31, 1, "R11");
        pulse(8'h02);
        #(2*Q);
        check(int_pull == 1'b1, "R11", "int reasserted", {7'd0, int_pull}, 8'h01);

        // R12: master ack repeats the byte
        rd_short(8'h33, 2, "R12");

        // R10: clear all
        wr_reg(8'h1A, 8'h80, "R10");
        check(int_pull == 1'b0, "R10", "int after clear", {7'd0, int_pull}, 8'h00);
        rd_short(8'h00, 1, "R10");

        #(4*Q);
        check(exp_q.size() == 0, "R4", "scoreboard drained", 8'(exp_q.size()), 8'h00);
        summary();
        $finish;
    end
endmodule